// File: doc/BRIEF.md
# Sixteen-channel ADC conversion sequencer with register front end

This block sits between a 32-bit register bus and a shared auxiliary ADC that serves sixteen input channels. Software writes a trigger bitmap to request conversions. It then polls a per-channel result register until the ready flag is set and reads the 12-bit sample from the same word. Inside the block, the requests wait in a pending set. The block hands them to the converter one at a time as a one-clock start pulse that carries a channel number. It accepts the converter's done strobe and data only while a conversion is actually in flight.

Conversions are requested on the 0-to-1 transition of a channel's trigger bit. Writing that bit back to 0 withdraws the channel's ready flag. The software sequence per sample is therefore clear, set, poll. A power-enable bit gates the whole request path. A separate scratch control word reads back whatever was written to it.

Top module: `adc_seq_regs`

## Requirements
- R1: After reset every mapped register reads 0, no request is pending, `conv_start` is 0 and `conv_chan` is 0.
- R2: Reads are combinational and return 0 whenever `bus_rd` is 0. Offset 0x00 is a 32-bit scratch word that reads back as written. Offset 0x94 stores only bit 14 (power enable) and reads 0 in every other bit. Any offset that is not mapped reads 0, including non-word-aligned offsets inside the result window.
- R3: Offset 0x04 holds the trigger bitmap in bits 15:0, with bit n belonging to channel n. A write that takes bit n from 0 to 1 while power is enabled adds channel n to the pending set.
- R4: A write that takes trigger bit n from 1 to 0 makes bit 12 (ready) of channel n's result register read 0 from the next cycle on. This holds even when a done for channel n is accepted in the same cycle, in which case the data is still stored.
- R5: When nothing is in flight, power is enabled and a request is pending, `conv_start` is high for exactly one cycle, beginning one clock after the edge that saw the pending request. `conv_chan` carries the chosen channel and holds it until the next start.
- R6: `conv_done` is accepted only while a conversion is in flight. On acceptance the result register at offset 0x14 + 4·n of the channel in flight stores `conv_data` in bits 11:0 and sets bit 12. A done that arrives while idle changes nothing.
- R7: When several channels are pending, they are started in ascending channel number, one conversion at a time. A new start can come no earlier than the cycle after the previous done has been accepted.
- R8: Bit 0 of offset 0x10 (busy) reads 1 while a conversion is in flight or any request is pending, and 0 otherwise.
- R9: While power enable is 0, trigger rises add nothing and no start is issued. Writing power enable to 0 empties the pending set, but a conversion already in flight still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read enable |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| conv_start | output | 1 | One-cycle request to begin a conversion |
| conv_chan | output | 4 | Channel of the conversion in flight |
| conv_done | input | 1 | Converter finished strobe |
| conv_data | input | 12 | Converter sample, valid with `conv_done` |

## Verification
Two functions can meet in one clock edge. A register write that drops or raises a trigger bit can coincide with the acceptance of a done from the converter. The bench provokes this by switching the converter model to manual mode, waiting for the start, and then issuing the trigger write in the very cycle it pulses done. In one case the write clears the channel in flight, and the result must show the stored data with ready at 0. In the other case the write raises a different channel, which must be queued and started after the finished conversion. A behavioural model that keeps the pending requests in a queue predicts the outputs and the addressed read value on every clock, so the outcome of each collision is judged cycle by cycle.

// File: rtl/adc_seq_regs.sv
module adc_seq_regs #(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 12,
  parameter int ADDR_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic [31:0]               bus_wdata,
  input  logic                      bus_rd,
  output logic [31:0]               bus_rdata,
  output logic                      conv_start,
  output logic [$clog2(NUM_CH)-1:0] conv_chan,
  input  logic                      conv_done,
  input  logic [DATA_W-1:0]         conv_data
);
  localparam int CH_W = $clog2(NUM_CH);
  localparam logic [ADDR_W-1:0] A_SCRATCH = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_TRIG    = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_STAT    = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_RES0    = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_PWR     = ADDR_W'('h94);
  localparam int RES_END = 'h14 + 4 * NUM_CH;
  localparam int PWR_BIT = 14;

  logic [31:0]       scratch_q;
  logic [NUM_CH-1:0] trig_q, pend_q, rdy_q;
  logic [DATA_W-1:0] data_q [NUM_CH];
  logic              pwr_q, active_q, start_q;
  logic [CH_W-1:0]   cur_q;

  logic              wr_trig, wr_pwr, done_ok, launch, busy;
  logic [NUM_CH-1:0] trig_new, rise, fall, pick_oh, done_oh;
  logic [CH_W-1:0]   pick;

  assign wr_trig  = bus_wr && bus_addr == A_TRIG;
  assign wr_pwr   = bus_wr && bus_addr == A_PWR;
  assign trig_new = bus_wdata[NUM_CH-1:0];
  assign rise     = wr_trig ? (trig_new & ~trig_q) : '0;
  assign fall     = wr_trig ? (trig_q & ~trig_new) : '0;
  assign done_ok  = active_q && conv_done;
  assign launch   = !active_q && pwr_q && |pend_q;
  assign busy     = active_q || |pend_q;
  assign pick_oh  = launch ? (NUM_CH'(1) << pick) : '0;
  assign done_oh  = done_ok ? (NUM_CH'(1) << cur_q) : '0;

  always_comb begin
    pick = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (pend_q[i]) pick = CH_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
      trig_q    <= '0;
      pend_q    <= '0;
      rdy_q     <= '0;
      pwr_q     <= 1'b0;
      active_q  <= 1'b0;
      start_q   <= 1'b0;
      cur_q     <= '0;
      for (int i = 0; i < NUM_CH; i++) data_q[i] <= '0;
    end else begin
      start_q <= launch;
      if (launch) begin
        active_q <= 1'b1;
        cur_q    <= pick;
      end else if (done_ok) begin
        active_q <= 1'b0;
      end
      if (wr_pwr && !bus_wdata[PWR_BIT]) pend_q <= '0;
      else pend_q <= (pend_q & ~pick_oh) | (pwr_q ? rise : '0);
      if (bus_wr && bus_addr == A_SCRATCH) scratch_q <= bus_wdata;
      if (wr_trig) trig_q <= trig_new;
      if (wr_pwr) pwr_q <= bus_wdata[PWR_BIT];
      if (done_ok) data_q[cur_q] <= conv_data;
      rdy_q <= (rdy_q | done_oh) & ~fall;
    end
  end

  assign conv_start = start_q;
  assign conv_chan  = cur_q;

  logic [ADDR_W-1:0] res_off;
  logic [CH_W-1:0]   res_idx;
  logic              in_res;
  logic [31:0]       rd_val;

  assign res_off = bus_addr - A_RES0;
  assign res_idx = res_off[CH_W+1:2];
  assign in_res  = int'(bus_addr) >= int'(A_RES0) && int'(bus_addr) < RES_END
                   && bus_addr[1:0] == 2'b00;

  always_comb begin
    rd_val = '0;
    if (bus_addr == A_SCRATCH)  rd_val = scratch_q;
    else if (bus_addr == A_TRIG) rd_val[NUM_CH-1:0] = trig_q;
    else if (bus_addr == A_STAT) rd_val[0] = busy;
    else if (bus_addr == A_PWR)  rd_val[PWR_BIT] = pwr_q;
    else if (in_res) begin
      rd_val[DATA_W]     = rdy_q[res_idx];
      rd_val[DATA_W-1:0] = data_q[res_idx];
    end
  end

  assign bus_rdata = bus_rd ? rd_val : '0;

  p_fall_clears_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_trig |=> ((rdy_q & $past(fall)) == '0));

  p_done_stores_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok && !fall[cur_q]) |=> (rdy_q[$past(cur_q)] && data_q[$past(cur_q)] == $past(conv_data)));

  p_idle_done_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && conv_done && !wr_trig) |=> $stable(rdy_q));

  p_start_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_chan_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !conv_start) |-> $stable(conv_chan));

  p_start_needs_power_r9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(pwr_q));

  p_power_off_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pwr && !bus_wdata[PWR_BIT]) |=> pend_q == '0);

  p_busy_with_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);
endmodule

// File: tb/test_adc_seq_regs.sv
`timescale 1ns/1ps
module test_adc_seq_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        conv_start;
  logic [3:0]  conv_chan;
  logic        conv_done;
  logic [11:0] conv_data;

  logic        auto_mode = 1'b1;
  logic        auto_done = 1'b0, man_done = 1'b0;
  logic [11:0] auto_data = '0, man_data = '0;
  assign conv_done = auto_done | man_done;
  assign conv_data = man_done ? man_data : auto_data;

  always #2 clk = ~clk;

  adc_seq_regs i_adc_seq_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_data(conv_data));

  int n_chk = 0, n_fail = 0;
  bit ph_reset = 1'b1;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_scratch;
  logic [15:0] m_trig;
  bit          m_pwr, m_active, m_start;
  int          m_cur;
  int          m_ready [16];
  int          m_data  [16];
  int          pq [$];

  function automatic bit in_q(input int ch);
    foreach (pq[k]) if (pq[k] == ch) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_scratch = 0; m_trig = 0; m_pwr = 0; m_active = 0; m_start = 0; m_cur = 0;
      for (int i = 0; i < 16; i++) begin m_ready[i] = 0; m_data[i] = 0; end
      pq.delete();
    end else begin
      bit launch, dn;
      int best, bk;
      dn = m_active && conv_done;
      launch = !m_active && m_pwr && pq.size() > 0;
      best = 99; bk = 0;
      if (launch) begin
        foreach (pq[k]) if (pq[k] < best) begin best = pq[k]; bk = k; end
        pq.delete(bk);
      end
      if (dn) begin m_data[m_cur] = conv_data; m_ready[m_cur] = 1; m_active = 0; end
      m_start = launch;
      if (launch) begin m_active = 1; m_cur = best; end
      if (bus_wr) begin
        if (bus_addr == 8'h00) m_scratch = bus_wdata;
        if (bus_addr == 8'h04) begin
          for (int i = 0; i < 16; i++) begin
            if (m_trig[i] && !bus_wdata[i]) m_ready[i] = 0;
            if (!m_trig[i] && bus_wdata[i] && m_pwr && !in_q(i)) pq.push_back(i);
          end
          m_trig = bus_wdata[15:0];
        end
        if (bus_addr == 8'h94) begin
          m_pwr = bus_wdata[14];
          if (!m_pwr) pq.delete();
        end
      end
    end
  end

  function automatic logic [31:0] exp_rd();
    int a;
    a = bus_addr;
    if (!bus_rd) return 32'h0;
    if (a == 'h00) return m_scratch;
    if (a == 'h04) return {16'h0, m_trig};
    if (a == 'h10) return {31'h0, (m_active || pq.size() > 0)};
    if (a == 'h94) return m_pwr ? 32'h4000 : 32'h0;
    if (a >= 'h14 && a < 'h54 && a % 4 == 0)
      return ((m_ready[(a - 'h14) / 4] != 0) ? 32'h1000 : 32'h0) | 32'(m_data[(a - 'h14) / 4]);
    return 32'h0;
  endfunction

  function automatic string tag_of();
    int a;
    a = bus_addr;
    if (ph_reset) return "R1";
    if (!bus_rd || a == 'h00 || a == 'h94) return "R2";
    if (a == 'h04) return "R3";
    if (a == 'h10) return "R8";
    if (a >= 'h14 && a < 'h54 && a % 4 == 0) return "R4/R6 result";
    return "R2 unmapped";
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk(32'(conv_start), 32'(m_start), ph_reset ? "R1 start" : "R5 start pulse");
      chk(32'(conv_chan), 32'(m_cur), ph_reset ? "R1 chan" : "R5/R7 channel");
      chk(bus_rdata, exp_rd(), tag_of());
    end
  end

  // converter model
  int cnt = 0, seed = 11, cch = 0;
  always @(negedge clk) begin
    #1;
    auto_done = 1'b0;
    if (!auto_mode) cnt = 0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        auto_done = 1'b1;
        auto_data = 12'((cch * 257 + seed) & 'hfff);
        seed += 37;
      end
    end
    if (conv_start && auto_mode) begin cnt = 5; cch = conv_chan; end
  end

  // stimulus
  int scan [$] = '{'h10, 'h14, 'h18, 'h1C, 'h20, 'h24, 'h28, 'h2C, 'h30, 'h34,
                   'h38, 'h3C, 'h40, 'h44, 'h48, 'h4C, 'h50, 'h00, 'h04, 'h94,
                   'h08, 'h0C, 'h98, 'h16, 'h54, 'hFC};
  int si = 0;

  task automatic cyc(); @(negedge clk); #1; endtask

  task automatic idle(input int n);
    repeat (n) begin
      cyc();
      bus_wr = 0; man_done = 0; bus_rd = 1;
      bus_addr = 8'(scan[si]);
      si = (si + 1) % scan.size();
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    cyc();
    man_done = 0; bus_rd = 0; bus_wr = 1; bus_addr = 8'(a); bus_wdata = d;
  endtask

  task automatic wr_done(input int a, input logic [31:0] d, input logic [11:0] s);
    cyc();
    bus_rd = 0; bus_wr = 1; bus_addr = 8'(a); bus_wdata = d;
    man_done = 1; man_data = s;
  endtask

  task automatic pulse_done(input logic [11:0] s);
    cyc();
    bus_wr = 0; bus_rd = 1; bus_addr = 8'h10; man_done = 1; man_data = s;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(32'(conv_start), 32'h0, "R1 start in reset");
    chk(32'(conv_chan), 32'h0, "R1 channel in reset");
    @(negedge clk); #1; rst_n = 1'b1;
    idle(scan.size() + 2);
    ph_reset = 1'b0;
    // R2 scratch and power readback
    wr('h00, 32'hA5A5_1234); idle(4);
    wr('h94, 32'hFFFF_FFFF); idle(4);
    // R3 single channel: set, poll, clear, set again
    wr('h04, 32'h0000_0008); idle(30);
    wr('h04, 32'h0); idle(6);
    wr('h04, 32'h0000_0008); idle(30);
    // R7 several rises in one write, ascending service
    wr('h04, 32'hFFFF_F0A9); idle(160);
    // R4 clear all while some may be in flight, then re-raise
    wr('h04, 32'h0); idle(4);
    wr('h04, 32'h0000_8421); idle(8);
    wr('h04, 32'h0000_0001); idle(60);
    wr('h04, 32'h0); idle(6);
    // R9 power off: rises ignored
    wr('h94, 32'h0); idle(4);
    wr('h04, 32'h0000_0042); idle(30);
    wr('h04, 32'h0); idle(2);
    // R9 power drop while queue busy: in-flight completes, rest dropped
    wr('h94, 32'h0000_4000); idle(2);
    wr('h04, 32'h0000_0F00); idle(3);
    wr('h94, 32'h0); idle(30);
    wr('h94, 32'h0000_4000); wr('h04, 32'h0); idle(4);
    // collision: trigger fall in the same cycle as done (R4, R6)
    auto_mode = 1'b0; idle(2);
    wr('h04, 32'h0000_0004); idle(4);
    wr_done('h04, 32'h0, 12'h5A5); idle(6);
    // collision: other channel rises in the same cycle as done (R3, R7)
    wr('h04, 32'h0000_0004); idle(4);
    wr_done('h04, 32'h0000_0204, 12'h3C3); idle(4);
    pulse_done(12'h777); idle(6);
    // stray done while idle is ignored (R6)
    pulse_done(12'hABC); idle(scan.size());
    wr('h04, 32'h0); idle(scan.size());
    auto_mode = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R5: watchdog expired, actual=running expected=finished");
    report();
    $finish;
  end
endmodule